// File: doc/BRIEF.md
# Reference Clock Selector with Loss Detection and Holdover

This block sits in front of a clock-multiplying PLL. It takes four reference clocks, watches each one for missing edges, and routes one of them to the PLL on `ref_out`. Every input has an invalid flag. Once that flag is raised, it stays up until the input has again toggled steadily for a set number of observation windows.

A two-bit mode input chooses how the reference is picked. In manual mode the choice comes from a two-bit code. That code passes through a deglitcher, so a brief change on it never moves the selection. In the two automatic modes the block picks the highest-priority valid input. The revertive variant moves back to a better input as soon as that input recovers. The non-revertive variant stays where it is until its current input fails.

When the PLL has no usable reference, the block raises a holdover request so the loop keeps its last frequency. Selection resumes on the first input that recovers. All logic runs in one system clock domain. The reference inputs are sampled in that domain through a synchronizer.

Top module: `refclk_selector`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all four alarms read 1111, `holdover` is 1, `ref_idx` is 0 and `ref_active` is 0001.
- R2: `mode_sel` 00 selects manual mode, 01 selects automatic non-revertive mode, and both 10 and 11 select automatic revertive mode.
- R3: In manual mode, `man_sel` code k (00, 01, 10, 11) selects input k+1, which is bit k of `ref_in`. `ref_idx` then reads k and `ref_out` follows `ref_in[k]`.
- R4: A new `man_sel` code takes effect only after it has held the same value for DGL_CYC consecutive clock cycles. A code that lasts fewer cycles leaves the selection unchanged.
- R5: An input's alarm bit rises at the end of an observation window of WIN_CYC clock cycles that contains no edge on that input.
- R6: A raised alarm clears only at the end of VALID_WINS consecutive windows that each contain an edge. A window with no edge restarts that count.
- R7: In revertive mode the selection is always the valid input with the lowest bit index (input 1 highest priority). It returns to a higher-priority input as soon as that input's alarm clears.
- R8: In non-revertive mode the selection stays on the current input while that input's alarm is low, even if a higher-priority input recovers.
- R9: In automatic mode, `holdover` is 1 and `ref_idx` holds its last value while all four alarms are set. When the first input recovers, `holdover` falls and that input is selected.
- R10: In manual mode, `holdover` equals the alarm bit of the selected input.
- R11: `ref_idx` and `ref_active` change in the same cycle, and `ref_active` always has exactly one bit set, at position `ref_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 4 | Reference clock inputs; bit 0 is input 1, the highest priority |
| mode_sel | input | 2 | Selection method: 00 manual, 01 auto non-revertive, 10/11 auto revertive |
| man_sel | input | 2 | Manual select code, deglitched |
| ref_out | output | 1 | Selected reference clock, sent to the PLL |
| ref_alarm | output | 4 | Per-input sticky invalid flags |
| ref_active | output | 4 | One-hot indicator of the selected input |
| ref_idx | output | 2 | Index of the selected input |
| holdover | output | 1 | Request for the PLL to freeze its frequency |

## Verification
The bench builds the block with WIN_CYC = 8 and VALID_WINS = 3, and keeps DGL_CYC at its default of 16. With such short windows, loss and recovery take only tens of cycles, so the bench can run a full fail, hold and recover sequence for each automatic mode. A short burst of edges that spans fewer than three windows exercises the sticky alarm. The 16-cycle deglitch is exercised with a 10-cycle pulse and with holds of 14 and 24 cycles on either side of the threshold.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int unsigned REF_N     = 4;
    localparam int unsigned REF_IDX_W = $clog2(REF_N);

    typedef logic [REF_N-1:0]     ref_vec_t;
    typedef logic [REF_IDX_W-1:0] ref_idx_t;

    typedef enum logic [1:0] {
        SEL_MANUAL       = 2'b00,
        SEL_AUTO_STAY    = 2'b01,
        SEL_AUTO_REVERT  = 2'b10,
        SEL_AUTO_REVERT2 = 2'b11
    } sel_mode_e;

    typedef struct packed {
        ref_idx_t idx;
        logic     freeze;
        ref_vec_t active;
    } sel_state_t;

    // Lowest set bit wins; returns 0 when nothing is set.
    function automatic ref_idx_t top_priority(ref_vec_t ok);
        ref_idx_t r;
        r = '0;
        for (int i = REF_N - 1; i >= 0; i--) begin
            if (ok[i]) r = ref_idx_t'(i);
        end
        return r;
    endfunction

    function automatic logic mode_is_auto(sel_mode_e m);
        return m != SEL_MANUAL;
    endfunction

    function automatic logic mode_is_revert(sel_mode_e m);
        return (m == SEL_AUTO_REVERT) || (m == SEL_AUTO_REVERT2);
    endfunction

    function automatic ref_vec_t idx_to_onehot(ref_idx_t i);
        return ref_vec_t'(1) << i;
    endfunction

endpackage

// File: rtl/refsel_los_mon.sv
module refsel_los_mon
    import refsel_pkg::*;
#(
    parameter int unsigned WIN_CYC    = 64,
    parameter int unsigned VALID_WINS = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  ref_vec_t ref_in,
    output ref_vec_t alarm
);

    localparam int unsigned WIN_W  = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam int unsigned GOOD_W = $clog2(VALID_WINS + 1);

    logic [WIN_W-1:0] win_cnt;
    logic             win_end;

    assign win_end = (win_cnt == WIN_W'(WIN_CYC - 1));

    // One window counter shared by every lane.
    always_ff @(posedge clk) begin
        if (rst || win_end) win_cnt <= '0;
        else                win_cnt <= win_cnt + 1'b1;
    end

    for (genvar g = 0; g < REF_N; g++) begin : g_lane
        logic [2:0]        sync;
        logic              seen;
        logic              alm;
        logic [GOOD_W-1:0] good;
        logic              edge_now;

        assign edge_now = sync[2] ^ sync[1];

        always_ff @(posedge clk) begin
            if (rst) begin
                sync <= '0;
                seen <= 1'b0;
                alm  <= 1'b1;
                good <= '0;
            end else begin
                sync <= {sync[1:0], ref_in[g]};
                if (win_end) begin
                    seen <= 1'b0;
                    if (seen || edge_now) begin
                        if (alm) begin
                            if (good == GOOD_W'(VALID_WINS - 1)) begin
                                alm  <= 1'b0;
                                good <= '0;
                            end else begin
                                good <= good + 1'b1;
                            end
                        end
                    end else begin
                        alm  <= 1'b1;
                        good <= '0;
                    end
                end else begin
                    seen <= seen | edge_now;
                end
            end
        end

        assign alarm[g] = alm;
    end

endmodule

// File: rtl/refsel_deglitch.sv
module refsel_deglitch
    import refsel_pkg::*;
#(
    parameter int unsigned DGL_CYC = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  ref_idx_t sel_raw,
    output ref_idx_t sel_clean
);

    localparam int unsigned CNT_W = $clog2(DGL_CYC + 1);

    ref_idx_t         cand;
    logic [CNT_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand      <= '0;
            run       <= '0;
            sel_clean <= '0;
        end else begin
            if (sel_raw != cand) begin
                cand <= sel_raw;
                run  <= CNT_W'(1);
            end else if (run != CNT_W'(DGL_CYC)) begin
                run <= run + 1'b1;
            end
            if (run == CNT_W'(DGL_CYC)) sel_clean <= cand;
        end
    end

endmodule

// File: rtl/refsel_arbiter.sv
module refsel_arbiter
    import refsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sel_mode_e  mode,
    input  ref_idx_t   man_idx,
    input  ref_vec_t   alarm,
    output sel_state_t state
);

    ref_vec_t   valid;
    sel_state_t nxt;

    assign valid = ~alarm;

    always_comb begin
        nxt = state;
        if (!mode_is_auto(mode)) begin
            nxt.idx    = man_idx;
            nxt.freeze = alarm[man_idx];
        end else if (valid == '0) begin
            nxt.freeze = 1'b1;
        end else begin
            nxt.freeze = 1'b0;
            if (mode_is_revert(mode) || !valid[state.idx]) begin
                nxt.idx = top_priority(valid);
            end
        end
        nxt.active = idx_to_onehot(nxt.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state.idx    <= '0;
            state.freeze <= 1'b1;
            state.active <= idx_to_onehot('0);
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
    import refsel_pkg::*;
#(
    parameter int unsigned WIN_CYC    = 64,
    parameter int unsigned VALID_WINS = 4,
    parameter int unsigned DGL_CYC    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] ref_in,
    input  logic [1:0] mode_sel,
    input  logic [1:0] man_sel,
    output logic       ref_out,
    output logic [3:0] ref_alarm,
    output logic [3:0] ref_active,
    output logic [1:0] ref_idx,
    output logic       holdover
);

    ref_vec_t   alarm_w;
    ref_idx_t   man_clean;
    sel_state_t sel;

    refsel_los_mon #(
        .WIN_CYC    (WIN_CYC),
        .VALID_WINS (VALID_WINS)
    ) u_mon (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .alarm  (alarm_w)
    );

    refsel_deglitch #(
        .DGL_CYC (DGL_CYC)
    ) u_dgl (
        .clk       (clk),
        .rst       (rst),
        .sel_raw   (man_sel),
        .sel_clean (man_clean)
    );

    refsel_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .mode    (sel_mode_e'(mode_sel)),
        .man_idx (man_clean),
        .alarm   (alarm_w),
        .state   (sel)
    );

    assign ref_alarm  = alarm_w;
    assign ref_active = sel.active;
    assign ref_idx    = sel.idx;
    assign holdover   = sel.freeze;
    assign ref_out    = ref_in[sel.idx];

endmodule

// File: rtl/refsel_checker.sv
module refsel_checker
    import refsel_pkg::*;
#(
    parameter int unsigned DGL_CYC = 16
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic [1:0] man_sel,
    input logic [3:0] ref_alarm,
    input logic [3:0] ref_active,
    input logic [1:0] ref_idx,
    input logic       holdover
);

    logic       is_man, is_stay, is_rev, is_auto;
    logic [1:0] last_sel;
    int unsigned run_cnt;

    assign is_man  = (mode_sel == 2'b00);
    assign is_stay = (mode_sel == 2'b01);
    assign is_rev  = mode_sel[1];
    assign is_auto = !is_man;

    // Count consecutive cycles the raw manual code has been steady.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_sel <= '0;
            run_cnt  <= 0;
        end else if (man_sel != last_sel) begin
            last_sel <= man_sel;
            run_cnt  <= 0;
        end else if (run_cnt < DGL_CYC + 4) begin
            run_cnt <= run_cnt + 1;
        end
    end

    assert_onehot_active_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(ref_active) == 1);

    assert_deglitch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (is_man && $past(is_man) && $past(is_man, 2) && ref_idx != $past(ref_idx))
            |-> (run_cnt >= DGL_CYC));

    assert_freeze_all_lost_R9: assert property (@(posedge clk) disable iff (rst)
        (is_auto && (&ref_alarm)) |=> (holdover || !is_auto));

    assert_revert_top_R7: assert property (@(posedge clk) disable iff (rst)
        (is_rev && !ref_alarm[0]) |=> (!is_rev || ref_idx == 2'd0));

    assert_stay_put_R8: assert property (@(posedge clk) disable iff (rst)
        (is_stay && !ref_alarm[ref_idx]) |=> (!is_stay || $stable(ref_idx)));

endmodule

bind refclk_selector refsel_checker #(
    .DGL_CYC (DGL_CYC)
) u_refsel_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .man_sel    (man_sel),
    .ref_alarm  (ref_alarm),
    .ref_active (ref_active),
    .ref_idx    (ref_idx),
    .holdover   (holdover)
);

// File: tb/refclk_selector_bench.sv
`timescale 1ns/1ps
module refclk_selector_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ref_q = 4'b0000;
    logic [3:0] ref_en = 4'b0000;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] man_sel = 2'b00;
    logic       ref_out;
    logic [3:0] ref_alarm;
    logic [3:0] ref_active;
    logic [1:0] ref_idx;
    logic       holdover;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    refclk_selector #(
        .WIN_CYC    (8),
        .VALID_WINS (3),
        .DGL_CYC    (16)
    ) u_refclk_selector (
        .clk        (clk),
        .rst        (rst),
        .ref_in     (ref_q),
        .mode_sel   (mode_sel),
        .man_sel    (man_sel),
        .ref_out    (ref_out),
        .ref_alarm  (ref_alarm),
        .ref_active (ref_active),
        .ref_idx    (ref_idx),
        .holdover   (holdover)
    );

    // Enabled references toggle every two system cycles.
    initial begin
        forever begin
            repeat (2) @(posedge clk);
            #1 ref_q = ref_q ^ ref_en;
        end
    end

    task automatic check_val(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_sel(input string req, input int exp_idx);
        check_val({req, " idx"}, ref_idx, exp_idx);
        check_val({req, " active"}, ref_active, 1 << exp_idx);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        wait_cyc(2);
        check_val("R1 alarm", ref_alarm, 4'b1111);
        check_val("R1 holdover", holdover, 1);
        check_sel("R1", 0);
        rst = 1'b0;
        wait_cyc(1);
        check_val("R1 alarm after release", ref_alarm, 4'b1111);
        check_sel("R1 after release", 0);
    endtask

    task automatic t_validate;
        ref_en = 4'b1111;
        wait_cyc(60);
        check_val("R6 all validated", ref_alarm, 4'b0000);
        check_val("R10 manual holdover low", holdover, 0);
        check_sel("R3 code 00", 0);
    endtask

    task automatic t_manual;
        man_sel = 2'b10;
        wait_cyc(14);
        check_sel("R4 before threshold", 0);
        wait_cyc(10);
        check_sel("R3 code 10", 2);
        for (int k = 0; k < 4; k++) begin
            check_val("R3 ref_out follows input 3", ref_out, ref_q[2]);
            wait_cyc(1);
        end
        man_sel = 2'b11;
        wait_cyc(10);
        man_sel = 2'b10;
        wait_cyc(40);
        check_sel("R4 short pulse ignored", 2);
        man_sel = 2'b11;
        wait_cyc(24);
        check_sel("R3 code 11", 3);
        man_sel = 2'b01;
        wait_cyc(24);
        check_sel("R3 code 01", 1);
        check_val("R3 ref_out follows input 2", ref_out, ref_q[1]);
        man_sel = 2'b00;
        wait_cyc(24);
        check_sel("R3 code 00 again", 0);
    endtask

    task automatic t_loss_sticky;
        ref_en[0] = 1'b0;
        wait_cyc(30);
        check_val("R5 input 1 lost", ref_alarm, 4'b0001);
        check_val("R10 manual holdover on lost input", holdover, 1);
        check_sel("R3 manual keeps lost input", 0);
        ref_en[0] = 1'b1;
        wait_cyc(7);
        ref_en[0] = 1'b0;
        wait_cyc(40);
        check_val("R6 short burst keeps alarm", ref_alarm[0], 1);
        ref_en[0] = 1'b1;
        wait_cyc(60);
        check_val("R6 revalidated", ref_alarm, 4'b0000);
        check_val("R10 holdover released", holdover, 0);
    endtask

    task automatic t_revertive;
        mode_sel = 2'b10;
        wait_cyc(3);
        check_sel("R7 start on input 1", 0);
        ref_en[1:0] = 2'b00;
        wait_cyc(30);
        check_sel("R7 skips two lost inputs", 2);
        ref_en[1] = 1'b1;
        wait_cyc(60);
        check_sel("R7 reverts to input 2", 1);
        ref_en[0] = 1'b1;
        wait_cyc(60);
        check_sel("R7 reverts to input 1", 0);
    endtask

    task automatic t_nonrev_holdover;
        mode_sel = 2'b01;
        ref_en[0] = 1'b0;
        wait_cyc(30);
        check_sel("R8 fails over to input 2", 1);
        ref_en[0] = 1'b1;
        wait_cyc(60);
        check_val("R8 input 1 recovered", ref_alarm, 4'b0000);
        check_sel("R8 stays on input 2", 1);
        ref_en = 4'b0000;
        wait_cyc(30);
        check_val("R9 all alarms", ref_alarm, 4'b1111);
        check_val("R9 holdover set", holdover, 1);
        check_sel("R9 index held", 1);
        ref_en = 4'b1000;
        wait_cyc(60);
        check_val("R9 holdover released", holdover, 0);
        check_sel("R9 first recovered input", 3);
        ref_en = 4'b1111;
        wait_cyc(60);
        check_sel("R8 stays after others recover", 3);
        mode_sel = 2'b11;
        wait_cyc(3);
        check_sel("R2 code 11 is revertive", 0);
    endtask

    initial begin
        t_reset();
        t_validate();
        t_manual();
        t_loss_sticky();
        t_revertive();
        t_nonrev_holdover();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule